// File: doc/BRIEF.md
# Triangle-Wave Spread-Spectrum Offset Generator

This block produces a digital triangle wave that is added, as a signed correction, to the frequency-control word of an oscillator. The modulation spreads the oscillator's energy over a band of frequencies. It runs on the clock it modulates. The offset sweeps linearly between a negative and a positive peak, and the sweep is symmetric about zero.

A 3-bit magnitude field sets the peak amplitude in binary steps. The smallest setting is one sixteenth of full scale, which corresponds to a 0.5 % span. The largest setting is full scale, which corresponds to an 8 % span. Full scale is a parameterised code count.

A 2-bit rate field stretches the triangle period from 4096 to 32768 clock cycles. A new value on either field takes effect only when the wave next passes through zero, so the output never jumps. A spread-enable input switches the modulation on and off. While the input is low the offset output is exactly zero. When it goes high, the wave starts again from the centre and rises first.

Top module: `spread_dither`

## Requirements
- R1: After reset, `offset_o` is 0 and `rising_o` is 1.
- R2: While `spread_en` is 0, the internal wave is held at zero and the direction is set to rising. From the next clock edge on, `offset_o` is 0 and `rising_o` is 1, whatever values `mag_sel` and `rate_sel` carry.
- R3: Once `spread_en` goes to 1, the wave starts at zero and first moves upward. It changes by exactly one full-scale code per step. A step occurs every 2^(BASE_PERIOD_LG2-PEAK_LG2-2+rate) clock edges, which is 4 << rate with the default parameters.
- R4: Rate codes 0, 1, 2 and 3 give triangle periods of 4096, 8192, 16384 and 32768 clock cycles at default parameters. After one full period, the wave is back at zero and rising.
- R5: The full-scale wave runs from zero up to +2^PEAK_LG2 (256 by default), down to -2^PEAK_LG2, and back up to zero. `rising_o` is 1 while the wave moves upward and 0 while it moves downward. It turns to 0 in the step that reaches the positive peak, and back to 1 in the step that reaches the negative peak.
- R6: `offset_o` is the full-scale wave arithmetically shifted right by 4 minus the magnitude code, for codes 0 to 4 (0.5 %, 1 %, 2 %, 4 %, 8 %). Codes 5, 6 and 7 give the same result as code 4.
- R7: While enabled, a change on `mag_sel` or `rate_sel` is captured only in the step that brings the wave to zero. Until then, the previous setting still governs both the scaling and the step interval.
- R8: `offset_o` is a two's-complement number PEAK_LG2+2 bits wide. It is registered, and it updates on the same clock edge as the wave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock that is being modulated |
| rst_n | input | 1 | Asynchronous reset, active low |
| spread_en | input | 1 | 1 applies the modulation; 0 forces the offset to zero |
| mag_sel | input | 3 | Peak amplitude code: 0 = 0.5 %, doubling per code up to 4 = 8 %; 5 to 7 act as 4 |
| rate_sel | input | 2 | Sweep period code: period = 4096 << code cycles |
| offset_o | output | PEAK_LG2+2 | Signed offset to add to the frequency-control word |
| rising_o | output | 1 | 1 while the wave sweeps upward, 0 while it sweeps downward |

## Verification
The assertions check four things on every cycle. While disabled, the offset is forced to zero on the next edge. The wave moves by at most one code between edges. It never leaves the band between the two full-scale peaks, and it turns downward on reaching the positive peak. Finally, the captured fields change only at a zero point.

Only the bench's scenarios can show the rest. These are the exact position of the wave after a given number of enabled cycles, the period for each rate code, the shift applied for each magnitude code (including the codes folded to full scale), and the delay before a field change takes effect at the next crossing.

// File: rtl/spread_dither_pkg.sv
package spread_dither_pkg;
    localparam int MAG_W     = 3;
    localparam int RATE_W    = 2;
    localparam int MAX_SHIFT = 4;

    typedef enum logic {
        PH_FALL = 1'b0,
        PH_RISE = 1'b1
    } phase_e;
endpackage

// File: rtl/spread_dither_rate_div.sv
module spread_dither_rate_div
    import spread_dither_pkg::*;
#(
    parameter int STEP_LG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              step
);
    localparam int DIV_W = STEP_LG2 + (1 << RATE_W) + 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = DIV_W'(1) << (STEP_LG2 + int'(rate));
        step  = run && (div_q >= limit - DIV_W'(1));
        if (!run || step) begin
            div_d = '0;
        end else begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/spread_dither_scale.sv
module spread_dither_scale
    import spread_dither_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic signed [TW-1:0]    wave_i,
    input  logic        [MAG_W-1:0] mag_i,
    output logic signed [TW-1:0]    off_o
);
    logic [MAG_W-1:0] shift;

    always_comb begin
        if (int'(mag_i) >= MAX_SHIFT) begin
            shift = '0;
        end else begin
            shift = MAG_W'(MAX_SHIFT) - mag_i;
        end
        off_o = wave_i >>> shift;
    end
endmodule

// File: rtl/spread_dither.sv
module spread_dither
    import spread_dither_pkg::*;
#(
    parameter int PEAK_LG2        = 8,
    parameter int BASE_PERIOD_LG2 = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           spread_en,
    input  logic [2:0]                     mag_sel,
    input  logic [1:0]                     rate_sel,
    output logic signed [PEAK_LG2+1:0]     offset_o,
    output logic                           rising_o
);
    localparam int TW        = PEAK_LG2 + 2;
    localparam int STEP_LG2  = BASE_PERIOD_LG2 - PEAK_LG2 - 2;
    localparam int FULL_PEAK = 1 << PEAK_LG2;
    localparam logic signed [TW-1:0] PEAK_POS = TW'(FULL_PEAK);
    localparam logic signed [TW-1:0] PEAK_NEG = -PEAK_POS;

    typedef struct packed {
        logic signed [TW-1:0] wave;
        phase_e               dir;
        logic [MAG_W-1:0]     mag;
        logic [RATE_W-1:0]    rate;
        logic signed [TW-1:0] off;
    } state_t;

    state_t s_d, s_q;

    logic                 step;
    logic signed [TW-1:0] wave_n;
    phase_e               dir_n;
    logic [MAG_W-1:0]     mag_n;
    logic [RATE_W-1:0]    rate_n;
    logic signed [TW-1:0] off_n;

    spread_dither_rate_div #(
        .STEP_LG2(STEP_LG2)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (spread_en),
        .rate (s_q.rate),
        .step (step)
    );

    always_comb begin
        wave_n = s_q.wave;
        dir_n  = s_q.dir;
        mag_n  = s_q.mag;
        rate_n = s_q.rate;
        if (!spread_en) begin
            wave_n = '0;
            dir_n  = PH_RISE;
            mag_n  = mag_sel;
            rate_n = rate_sel;
        end else if (step) begin
            if (s_q.dir == PH_RISE) begin
                wave_n = s_q.wave + TW'(1);
                if (wave_n == PEAK_POS) dir_n = PH_FALL;
            end else begin
                wave_n = s_q.wave - TW'(1);
                if (wave_n == PEAK_NEG) dir_n = PH_RISE;
            end
            if (wave_n == '0) begin
                mag_n  = mag_sel;
                rate_n = rate_sel;
            end
        end
    end

    spread_dither_scale #(
        .TW(TW)
    ) u_scale (
        .wave_i(wave_n),
        .mag_i (mag_n),
        .off_o (off_n)
    );

    always_comb begin
        s_d.wave = wave_n;
        s_d.dir  = dir_n;
        s_d.mag  = mag_n;
        s_d.rate = rate_n;
        s_d.off  = off_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.wave <= '0;
            s_q.dir  <= PH_RISE;
            s_q.mag  <= '0;
            s_q.rate <= '0;
            s_q.off  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign offset_o = s_q.off;
    assign rising_o = (s_q.dir == PH_RISE);

    // R2: a disabled cycle clears the offset on the following edge
    assert_idle_offset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spread_en |=> (offset_o == '0));

    // R3: the wave moves by at most one code per edge while enabled
    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && $past(spread_en)) |->
            ((s_q.wave == $past(s_q.wave)) ||
             (s_q.wave == $past(s_q.wave) + TW'(1)) ||
             (s_q.wave == $past(s_q.wave) - TW'(1))));

    // R5: the wave stays within the full-scale band
    assert_peak_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wave <= PEAK_POS) && (s_q.wave >= PEAK_NEG));

    // R5: reaching the upper peak turns the sweep downward
    assert_turn_at_peak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wave == PEAK_POS) |-> !rising_o);

    // R7: captured fields change only at a zero point while enabled
    assert_fields_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_en && $past(spread_en) && !$stable({s_q.mag, s_q.rate})) |->
            (s_q.wave == '0));
endmodule

// File: tb/spread_dither_tb.sv
module spread_dither_tb;
    localparam int TW = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 spread_en = 1'b0;
    logic [2:0]           mag_sel = 3'd0;
    logic [1:0]           rate_sel = 2'd0;
    logic signed [TW-1:0] offset_o;
    logic                 rising_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    spread_dither u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spread_en(spread_en),
        .mag_sel  (mag_sel),
        .rate_sel (rate_sel),
        .offset_o (offset_o),
        .rising_o (rising_o)
    );

    typedef struct packed {
        logic [2:0] mag;
        logic [1:0] rate;
        int         cyc;
        int         off;
        logic       ph;
    } vec_t;

    // enabled cycles -> steps = cyc / (4 << rate); expected offset and phase
    localparam vec_t VEC [9] = '{
        '{3'd4, 2'd0,   400,  100, 1'b1},  // R3 rising ramp
        '{3'd4, 2'd0,  1024,  256, 1'b0},  // R5 upper peak, turned down
        '{3'd4, 2'd0,  2048,    0, 1'b0},  // R5 falling through zero
        '{3'd4, 2'd0,  3072, -256, 1'b1},  // R5 lower peak, turned up
        '{3'd0, 2'd0,   400,    6, 1'b1},  // R6 0.5 %
        '{3'd2, 2'd1,  2400,   53, 1'b0},  // R6/R4 2 %, rate 1
        '{3'd1, 2'd3, 22400,  -24, 1'b0},  // R6/R4 1 %, rate 3, floor on negative
        '{3'd7, 2'd2,  1600,  100, 1'b1},  // R6 code 7 acts as full scale
        '{3'd3, 2'd0,  4096,    0, 1'b1}   // R4 one full period
    };

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic go_idle(logic [2:0] m, logic [1:0] r);
        @(negedge clk);
        spread_en = 1'b0;
        mag_sel   = m;
        rate_sel  = r;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 offset in reset", int'(offset_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 offset after reset", int'(offset_o), 0);
        check("R1 phase after reset", int'(rising_o), 1);

        foreach (VEC[i]) begin
            go_idle(VEC[i].mag, VEC[i].rate);
            check("R2 idle offset", int'(offset_o), 0);
            spread_en = 1'b1;
            repeat (VEC[i].cyc) @(posedge clk);
            @(negedge clk);
            check("R3/R4/R5/R6 vector offset", int'(offset_o), VEC[i].off);
            check("R5 vector phase", int'(rising_o), int'(VEC[i].ph));
        end

        // R2: fields toggled while idle have no effect, wave held at centre
        go_idle(3'd4, 2'd0);
        repeat (20) begin
            @(negedge clk);
            mag_sel  = mag_sel + 3'd1;
            rate_sel = rate_sel + 2'd1;
        end
        check("R2 offset while idle", int'(offset_o), 0);
        check("R2 phase while idle", int'(rising_o), 1);
        mag_sel  = 3'd4;
        rate_sel = 2'd0;
        @(negedge clk);
        spread_en = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R3 restart from centre", int'(offset_o), 5);

        // R7: field change waits for zero crossing
        go_idle(3'd4, 2'd0);
        spread_en = 1'b1;
        repeat (100) @(posedge clk);
        @(negedge clk);
        mag_sel  = 3'd0;
        rate_sel = 2'd1;
        repeat (500) @(posedge clk);
        @(negedge clk);
        check("R7 old setting kept before crossing", int'(offset_o), 150);
        repeat (1528) @(posedge clk);
        @(negedge clk);
        check("R7 new setting after crossing", int'(offset_o), -1);
        check("R7 phase after crossing", int'(rising_o), 0);

        // R8: negative full-scale code fits width in two's complement
        go_idle(3'd5, 2'd0);
        spread_en = 1'b1;
        repeat (3072) @(posedge clk);
        @(negedge clk);
        check("R8 signed width at lower peak", int'(offset_o), -256);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule